// File: doc/BRIEF.md
# Threshold Inertial Interrupt Generator

This block watches three signed acceleration axes (X, Y, Z) that arrive together with a one-cycle valid strobe. On every strobe it compares the magnitude of each axis against a programmable threshold, which yields a "high" and a "low" event per axis. It then combines those six events into a single condition using one of four modes:
- OR of the enabled events.
- AND of the enabled events.
- Movement recognition, which fires once when the orientation settles into one of six zones.
- Position recognition, which holds while the orientation stays in such a zone.

A minimum-duration qualifier delays recognition until the condition has held for a programmed number of consecutive samples. A status register reports the six per-axis flags and an interrupt-active bit. Reading the status register clears the interrupt-active bit. An optional latch holds the status until that read.

Recognition is driven by a three-state machine, clocked only on sample strobes:
- **IDLE**: the condition is absent.
- **WAIT**: the condition is present but the duration has not yet been met.
- **ACTIVE**: the condition is recognised.

The transitions are:
- IDLE→ACTIVE when the condition appears and the duration is zero.
- IDLE→WAIT when the condition appears and the duration is nonzero.
- WAIT→ACTIVE once the count of earlier qualifying samples reaches the duration.
- WAIT→IDLE and ACTIVE→IDLE when the condition drops.
- Every other case stays in the current state.

Each entry into ACTIVE is the interrupt event. Registers are written and read through plain strobes with a 2-bit select.

Top module: `inertial_evt_irq`

## Requirements
- R1: After reset `irq` is 0, and the configuration register and status register (select 3) both read 0.
- R2: For each axis, the high event is true when the magnitude of the signed sample exceeds threshold×256 (the magnitude of -32768 counts as 32768). The low event is its complement, so a magnitude equal to the limit is low. The status bit positions are: bit0 X-low, bit1 X-high, bit2 Y-low, bit3 Y-high, bit4 Z-low, bit5 Z-high, bit6 interrupt-active, bit7 always 0. The six flags take each new sample's events unless they are latched.
- R3: When configuration bits [7:6] = 00, the condition is the OR of the events enabled by configuration bits [5:0], which use the same layout as status bits [5:0]. When not latched, `irq` falls on the first sample whose condition is false.
- R4: When configuration bits [7:6] = 10, the condition is true only if every enabled event is true and at least one event is enabled.
- R5: When configuration bits [7:6] = 01 (movement), a known zone means exactly one axis has an enabled high event. `irq` rises on the sample that moves from an unknown zone into a known zone. When not latched, it falls on the next sample. A direct change from one known zone to another does not fire.
- R6: When configuration bits [7:6] = 11 (position), `irq` is 1 for as long as the samples stay in a known zone and 0 once they leave it.
- R7: The duration register bits [6:0] give a value D. The condition is recognised on the (D+1)th consecutive qualifying sample, and any non-qualifying sample restarts the count. D = 0 recognises on the first qualifying sample.
- R8: A status read returns the status before it is cleared, and then clears the interrupt-active bit and `irq`. `irq` stays 0 until the next entry into recognition.
- R9: When threshold register bit 7 is 1 (latch), the interrupt-active bit, `irq` and the six flags captured at the event all hold until a status read.
- R10: The register selects are 0 configuration, 1 threshold (bits [6:0] threshold, bit 7 latch), 2 duration and 3 status (read only). Written registers read back their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | One-cycle strobe marking a new X/Y/Z sample |
| sample_x | input | 16 | Signed X sample |
| sample_y | input | 16 | Signed Y sample |
| sample_z | input | 16 | Signed Z sample |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe; a read of select 3 clears the interrupt |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 8 | Read data (combinational, value before any clear) |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with its defaults: 16-bit samples, a 7-bit threshold scaled by a shift of 8, and a 7-bit duration. With these values a threshold code of 0x10 puts the high/low boundary at exactly 4096. This makes the equality corner (4096 versus 4097) and the full-scale negative sample -32768 reachable with plain sample values. The 7-bit duration lets short runs of 3 to 4 samples show both a qualifier that is met and one that is broken.

// File: rtl/ig_pkg.sv
package ig_pkg;
    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_THS  = 2'd1,
        SEL_DUR  = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_OR   = 2'b00,
        MODE_MOVE = 2'b01,
        MODE_AND  = 2'b10,
        MODE_POS  = 2'b11
    } comb_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_ACTIVE = 2'd2
    } rec_state_e;
endpackage

// File: rtl/ig_axis_cmp.sv
module ig_axis_cmp #(
    parameter int AXIS_W    = 16,
    parameter int THS_W     = 7,
    parameter int THS_SHIFT = 8
) (
    input  logic signed [AXIS_W-1:0] smp,
    input  logic [THS_W-1:0]         ths,
    output logic                     above
);
    localparam int MAG_W = AXIS_W + 1;
    localparam int LIM_W = THS_W + THS_SHIFT;

    logic signed [MAG_W-1:0] ext;
    logic [MAG_W-1:0]        mag;
    logic [LIM_W-1:0]        lim;

    always_comb begin
        ext   = {smp[AXIS_W-1], smp};
        mag   = ext[MAG_W-1] ? MAG_W'(-ext) : MAG_W'(ext);
        lim   = {ths, {THS_SHIFT{1'b0}}};
        above = mag > MAG_W'(lim);
    end
endmodule

// File: rtl/ig_combiner.sv
module ig_combiner
    import ig_pkg::*;
(
    input  logic [5:0]  evt,
    input  logic [5:0]  en,
    input  comb_mode_e  mode,
    output logic        cond
);
    logic [2:0] hi_en;

    always_comb begin
        hi_en = {evt[5] & en[5], evt[3] & en[3], evt[1] & en[1]};
        unique case (mode)
            MODE_OR:   cond = |(evt & en);
            MODE_AND:  cond = (&(evt | ~en)) && (en != 6'd0);
            MODE_MOVE,
            MODE_POS:  cond = ($countones(hi_en) == 1);
            default:   cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/ig_dur_fsm.sv
module ig_dur_fsm
    import ig_pkg::*;
#(
    parameter int DUR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             cond,
    input  logic [DUR_W-1:0] dur,
    output logic             enter,
    output logic             nxt_active
);
    rec_state_e       st_q, st_d;
    logic [DUR_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (step) begin
            unique case (st_q)
                ST_IDLE: begin
                    cnt_d = DUR_W'(1);
                    if (cond) st_d = (dur == '0) ? ST_ACTIVE : ST_WAIT;
                end
                ST_WAIT: begin
                    if (!cond)              st_d = ST_IDLE;
                    else if (cnt_q >= dur)  st_d = ST_ACTIVE;
                    else                    cnt_d = cnt_q + DUR_W'(1);
                end
                ST_ACTIVE: begin
                    if (!cond) st_d = ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        enter      = step && (st_q != ST_ACTIVE) && (st_d == ST_ACTIVE);
        nxt_active = (st_d == ST_ACTIVE);
    end

    // R7: a nonzero duration never recognises on the first qualifying sample
    p_dur_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q == ST_IDLE && dur != '0) |=> (st_q != ST_ACTIVE));
endmodule

// File: rtl/inertial_evt_irq.sv
module inertial_evt_irq
    import ig_pkg::*;
#(
    parameter int AXIS_W    = 16,
    parameter int THS_W     = 7,
    parameter int DUR_W     = 7,
    parameter int THS_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [AXIS_W-1:0] sample_x,
    input  logic [AXIS_W-1:0] sample_y,
    input  logic [AXIS_W-1:0] sample_z,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    output logic [7:0]        rd_data,
    output logic              irq
);
    localparam int NAX = 3;

    logic [REG_W-1:0] cfg_q, ths_q, dur_q;
    logic [5:0]       flg_q;
    logic             ia_q;
    logic [NAX-1:0]   above;
    logic [5:0]       evt;
    logic             cond, enter, nxt_active;
    logic             latch_on, rd_clr, is_move;
    comb_mode_e       mode;

    logic signed [AXIS_W-1:0] smp [NAX];
    assign smp[0] = sample_x;
    assign smp[1] = sample_y;
    assign smp[2] = sample_z;

    for (genvar i = 0; i < NAX; i++) begin : g_axis
        ig_axis_cmp #(
            .AXIS_W(AXIS_W), .THS_W(THS_W), .THS_SHIFT(THS_SHIFT)
        ) u_cmp (
            .smp(smp[i]), .ths(ths_q[THS_W-1:0]), .above(above[i])
        );
        assign evt[2*i]   = ~above[i];
        assign evt[2*i+1] =  above[i];
    end

    assign mode     = comb_mode_e'(cfg_q[7:6]);
    assign latch_on = ths_q[7];
    assign is_move  = (mode == MODE_MOVE);
    assign rd_clr   = rd_en && (reg_sel_e'(rd_sel) == SEL_STAT);

    ig_combiner u_comb (
        .evt(evt), .en(cfg_q[5:0]), .mode(mode), .cond(cond)
    );

    ig_dur_fsm #(.DUR_W(DUR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .step(sample_valid), .cond(cond),
        .dur(dur_q[DUR_W-1:0]), .enter(enter), .nxt_active(nxt_active)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            ths_q <= '0;
            dur_q <= '0;
        end else if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_CFG:  cfg_q <= wr_data;
                SEL_THS:  ths_q <= wr_data;
                SEL_DUR:  dur_q <= wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ia_q  <= 1'b0;
            flg_q <= '0;
        end else begin
            if (sample_valid && !(latch_on && ia_q)) flg_q <= evt;
            if (sample_valid && enter)
                ia_q <= 1'b1;
            else if (rd_clr)
                ia_q <= 1'b0;
            else if (sample_valid && !latch_on && (is_move || !nxt_active))
                ia_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            SEL_CFG:  rd_data = cfg_q;
            SEL_THS:  rd_data = ths_q;
            SEL_DUR:  rd_data = dur_q;
            SEL_STAT: rd_data = {1'b0, ia_q, flg_q};
            default:  rd_data = '0;
        endcase
    end

    assign irq = ia_q;

    // R8: a status read without a new sample leaves the interrupt low
    p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !sample_valid) |=> !irq);

    // R9: a latched interrupt holds until a status read
    p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_on && irq && !rd_clr && !wr_en) |=> irq);

    // R5: movement mode interrupt lasts a single sample period when unlatched
    p_move_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_move && !latch_on && irq && sample_valid && !wr_en) |=> !irq);

    // R2: exactly one of high/low per axis in the held flags
    p_flag_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_q != 6'd0) |-> (flg_q[0] != flg_q[1] && flg_q[2] != flg_q[3] && flg_q[4] != flg_q[5]));
endmodule

// File: tb/inertial_evt_irq_tb.sv
module inertial_evt_irq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [15:0] sample_x = '0, sample_y = '0, sample_z = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic [7:0]  rd_data;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    inertial_evt_irq u_dut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .sample_x(sample_x), .sample_y(sample_y), .sample_z(sample_z),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic smp(input int x, input int y, input int z);
        @(negedge clk);
        sample_x = 16'(x); sample_y = 16'(y); sample_z = 16'(z);
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = sel;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rreg(2'd0, d); chk("R1 cfg", d, 8'h00);
        rreg(2'd3, d); chk("R1 status", d, 8'h00);
    endtask

    task automatic t_regs;
        logic [7:0] d;
        wreg(2'd1, 8'h10); wreg(2'd2, 8'h00); wreg(2'd0, 8'h02);
        rreg(2'd0, d); chk("R10 cfg readback", d, 8'h02);
        rreg(2'd1, d); chk("R10 ths readback", d, 8'h10);
    endtask

    task automatic t_or;
        logic [7:0] d;
        smp(5000, 0, 0);    chk("R3 or fire", {7'd0, irq}, 8'h01);
        rreg(2'd3, d);      chk("R8 status before clear", d, 8'h56);
        chk("R8 irq cleared", {7'd0, irq}, 8'h00);
        smp(5000, 0, 0);    chk("R8 no refire while active", {7'd0, irq}, 8'h00);
        smp(100, 0, 0);     chk("R3 or drop", {7'd0, irq}, 8'h00);
        rreg(2'd3, d);      chk("R2 low flags", d, 8'h15);
        smp(-5000, 0, 0);   chk("R2 negative magnitude", {7'd0, irq}, 8'h01);
        smp(4096, 0, 0);    chk("R2 equal is low", {7'd0, irq}, 8'h00);
        smp(4097, 0, 0);    chk("R2 above limit", {7'd0, irq}, 8'h01);
        smp(0, 0, 0);       chk("R3 clear", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_and;
        wreg(2'd0, 8'h8A);
        smp(5000, 0, 0);     chk("R4 partial", {7'd0, irq}, 8'h00);
        smp(5000, -6000, 0); chk("R4 all", {7'd0, irq}, 8'h01);
        smp(0, 0, 0);        chk("R4 drop", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_dur;
        wreg(2'd0, 8'h02); wreg(2'd2, 8'h03);
        for (int i = 0; i < 3; i++) begin
            smp(5000, 0, 0); chk("R7 not yet", {7'd0, irq}, 8'h00);
        end
        smp(5000, 0, 0); chk("R7 met on D+1", {7'd0, irq}, 8'h01);
        smp(0, 0, 0);
        smp(5000, 0, 0); smp(5000, 0, 0); smp(0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            smp(5000, 0, 0); chk("R7 restarted", {7'd0, irq}, 8'h00);
        end
        smp(5000, 0, 0); chk("R7 restart met", {7'd0, irq}, 8'h01);
        smp(0, 0, 0);
        wreg(2'd2, 8'h00);
    endtask

    task automatic t_latch;
        logic [7:0] d;
        wreg(2'd1, 8'h90);
        smp(5000, 0, 0); chk("R9 fire", {7'd0, irq}, 8'h01);
        smp(0, 0, 0);
        smp(0, 0, 0);    chk("R9 held", {7'd0, irq}, 8'h01);
        rreg(2'd3, d);   chk("R9 frozen status", d, 8'h56);
        chk("R9 cleared by read", {7'd0, irq}, 8'h00);
        smp(0, 0, 0);
        rreg(2'd3, d);   chk("R9 flags resume", d, 8'h15);
        wreg(2'd1, 8'h10);
    endtask

    task automatic t_move;
        wreg(2'd0, 8'h6A);
        smp(5000, 0, 0);    chk("R5 enter zone", {7'd0, irq}, 8'h01);
        smp(5000, 0, 0);    chk("R5 one period", {7'd0, irq}, 8'h00);
        smp(0, 5000, 0);    chk("R5 zone to zone", {7'd0, irq}, 8'h00);
        smp(5000, 5000, 0); chk("R5 unknown", {7'd0, irq}, 8'h00);
        smp(0, 5000, 0);    chk("R5 reenter", {7'd0, irq}, 8'h01);
        smp(0, 0, 0);       chk("R5 leave", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_pos;
        logic [7:0] d;
        wreg(2'd0, 8'hEA);
        smp(5000, 0, 0);    chk("R6 in zone", {7'd0, irq}, 8'h01);
        smp(5000, 0, 0);    chk("R6 holds", {7'd0, irq}, 8'h01);
        smp(5000, 5000, 0); chk("R6 leaves", {7'd0, irq}, 8'h00);
        smp(0, 0, -32768);  chk("R6 full scale negative", {7'd0, irq}, 8'h01);
        rreg(2'd3, d);      chk("R2 z high flags", d, 8'h65);
        smp(0, 0, -32768);  chk("R8 stays clear", {7'd0, irq}, 8'h00);
        smp(0, 0, 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_or;
        t_and;
        t_dur;
        t_latch;
        t_move;
        t_pos;
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run;
    end
endmodule